// File: doc/BRIEF.md
# ISA I/O Peripheral Slave Interface

This block sits on an add-in card and answers I/O read and I/O write cycles issued on a 16-bit ISA expansion bus. It compares the low sixteen address lines with a fixed 32-byte window. A cycle is accepted only while the address-enable line is low, because a high level means the DMA controller owns the bus. Within the window, each even/odd address pair selects one 16-bit register in a small internal register file.

For a read, the block drives the selected register onto the data bus once the synchronised read strobe is seen. It stops driving as soon as the strobe goes away. For a write, the block samples the bus data on every clock the write strobe is low. It commits the last sample when the synchronised strobe deasserts. The block pulls the channel-ready line low as soon as a decoded address and a command are present, so that slow accesses are stretched by a fixed number of bus clocks. It pulls the 16-bit chip-select line low for registers that accept word transfers. The byte-high enable and address bit 0 choose which byte lanes carry data.

Top module: `isa_io_slave`

## Requirements
- R1: An access hits when address bits 15:0 fall within BASE_ADDR to BASE_ADDR+2^WIN_LOG2-1 (default 0x300 to 0x31F). Address bits 19:16 are ignored. The register index is address bits WIN_LOG2-1:1. A miss never writes a register, never drives the data bus, leaves `iocs16_n` high and leaves `chrdy` high.
- R2: While `aen` is high, every cycle is ignored: no register changes, `data_oe` stays 0, and `iocs16_n` and `chrdy` stay high.
- R3: On a hit read, `data_oe` goes high once the read strobe has been low for SYNC_STAGES rising clock edges. It falls combinationally when `ior_n` returns high. It is never high while `iow_n` is low or while `ior_n` is high.
- R4: Write data, byte enables and index are sampled on every rising edge at which `iow_n` is low. The last sample is committed on the third rising edge after `iow_n` rises, so data changed during the strobe is written with its final value.
- R5: Byte lanes are selected by {addr[0], sbhe_n}. With 00, the whole word moves on bits 15:0. With 01, the low byte moves on bits 7:0. With 10, the high byte moves on bits 15:8. With 11, the high byte moves on bits 7:0. When `data_oe` is high, lanes not carrying data read as zero.
- R6: `iocs16_n` is low, combinationally from the address and `aen`, exactly when the address hits and bit [index] of WIDE_MASK is set. The default mask marks the lower half of the registers.
- R7: A register whose WIDE_MASK bit is clear holds only a low byte. Its high byte reads as zero, and writes aimed at its high byte are ignored.
- R8: `chrdy` falls combinationally when a hit address and a read or write strobe are present. It rises again after exactly WAIT_STATES rising edges and stays high until the command ends.
- R9: With WAIT_STATES = 0, `chrdy` never goes low.
- R10: Reset (`rst` high, synchronous) clears every register, so every location reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Active-high synchronous reset |
| addr | input | 20 | System address bus |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| aen | input | 1 | Address enable, high while DMA owns the bus |
| sbhe_n | input | 1 | Byte-high enable, active low |
| data_in | input | 16 | Data bus as seen at the pads |
| data_out | output | 16 | Data driven toward the pads |
| data_oe | output | 1 | Tristate drive enable for data_out |
| iocs16_n | output | 1 | 16-bit I/O chip select, active low |
| chrdy | output | 1 | Channel ready, low inserts wait states |

## Verification
The bench builds the main instance with the defaults (base 0x300, 32-byte window, two synchroniser stages, lower eight registers word-wide) and three wait states. Three wait states let the bench see ready still low after two edges and high after the third. A second copy with zero wait states shares the same bus and shows that ready never drops. With only sixteen registers, every register can be written and read in all four lane modes, and every address from 0x2F0 to 0x340 can be swept for chip select with the address-enable line both low and high.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

  localparam int BUS_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int IO_DEC_W = 16;

  // True when the low I/O address bits match the base outside the window offset
  function automatic logic io_window_hit(input logic [19:0] a,
                                         input logic [19:0] base,
                                         input int          win_log2,
                                         input logic        aen_in);
    logic [IO_DEC_W-1:0] keep;
    keep = ~IO_DEC_W'((32'd1 << win_log2) - 32'd1);
    return !aen_in && (((a[IO_DEC_W-1:0] ^ base[IO_DEC_W-1:0]) & keep) == '0);
  endfunction

  // Merge bus data into a stored word according to the lane selection
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old,
                                                  input logic [BUS_W-1:0] din,
                                                  input logic             a0,
                                                  input logic             sbhe_n,
                                                  input logic             wide);
    logic [BUS_W-1:0] r;
    r = old;
    case ({a0, sbhe_n})
      2'b00:   r = din;
      2'b01:   r[BYTE_W-1:0] = din[BYTE_W-1:0];
      2'b10:   r[BUS_W-1:BYTE_W] = din[BUS_W-1:BYTE_W];
      default: r[BUS_W-1:BYTE_W] = din[BYTE_W-1:0];
    endcase
    if (!wide) r[BUS_W-1:BYTE_W] = '0;
    return r;
  endfunction

  // Place a stored word on the bus lanes selected by the access
  function automatic logic [BUS_W-1:0] lane_present(input logic [BUS_W-1:0] word,
                                                    input logic             a0,
                                                    input logic             sbhe_n);
    logic [BUS_W-1:0] r;
    case ({a0, sbhe_n})
      2'b00:   r = word;
      2'b01:   r = {{BYTE_W{1'b0}}, word[BYTE_W-1:0]};
      2'b10:   r = {word[BUS_W-1:BYTE_W], {BYTE_W{1'b0}}};
      default: r = {{BYTE_W{1'b0}}, word[BUS_W-1:BYTE_W]};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/io_cmd_sync.sv
module io_cmd_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ior_n,
  input  logic iow_n,
  output logic rd_active,
  output logic wr_active
);
  logic [SYNC_STAGES-1:0] rd_sh;
  logic [SYNC_STAGES-1:0] wr_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sh <= '0;
      wr_sh <= '0;
    end else begin
      rd_sh <= {rd_sh[SYNC_STAGES-2:0], ~ior_n};
      wr_sh <= {wr_sh[SYNC_STAGES-2:0], ~iow_n};
    end
  end

  assign rd_active = rd_sh[SYNC_STAGES-1];
  assign wr_active = wr_sh[SYNC_STAGES-1];
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen #(
  parameter int WAIT_STATES = 2,
  parameter int CNT_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cycle_active,
  output logic [CNT_W-1:0] wait_cnt
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_STATES);

  always_ff @(posedge clk) begin
    if (rst)                    wait_cnt <= '0;
    else if (!cycle_active)     wait_cnt <= '0;
    else if (wait_cnt != LIMIT) wait_cnt <= wait_cnt + 1'b1;
  end
endmodule

// File: rtl/io_regfile.sv
module io_regfile
  import isa_io_pkg::*;
#(
  parameter int                    NUM_REGS  = 16,
  parameter int                    IDX_W     = 4,
  parameter logic [NUM_REGS-1:0]   WIDE_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_a0,
  input  logic             wr_sbhe_n,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [BUS_W-1:0] rd_word
);
  logic [BUS_W-1:0] words [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BUS_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        q <= lane_merge(q, wr_data, wr_a0, wr_sbhe_n, WIDE_MASK[i]);
    end
    assign words[i] = q;
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
  import isa_io_pkg::*;
#(
  parameter logic [19:0] BASE_ADDR   = 20'h00300,
  parameter int          WIN_LOG2    = 5,
  parameter int          WAIT_STATES = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [(1 << (WIN_LOG2 - 1)) - 1:0] WIDE_MASK =
    {(1 << (WIN_LOG2 - 2)){1'b1}}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [19:0] addr,
  input  logic        ior_n,
  input  logic        iow_n,
  input  logic        aen,
  input  logic        sbhe_n,
  input  logic [15:0] data_in,
  output logic [15:0] data_out,
  output logic        data_oe,
  output logic        iocs16_n,
  output logic        chrdy
);
  localparam int NUM_REGS = 1 << (WIN_LOG2 - 1);
  localparam int IDX_W    = WIN_LOG2 - 1;
  localparam int CNT_W    = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);

  // Decode, named for the checker
  logic             addr_hit;
  logic [IDX_W-1:0] rd_idx;
  logic             cmd_hit;
  assign addr_hit = io_window_hit(addr, BASE_ADDR, WIN_LOG2, aen);
  assign rd_idx   = addr[WIN_LOG2-1:1];
  assign cmd_hit  = addr_hit && (!ior_n || !iow_n);
  assign iocs16_n = !(addr_hit && WIDE_MASK[rd_idx]);

  // Strobe synchronisation
  logic rd_active, wr_active, wr_prev, wr_release;
  io_cmd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ior_n(ior_n), .iow_n(iow_n),
    .rd_active(rd_active), .wr_active(wr_active)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b0;
    else     wr_prev <= wr_active;
  end
  assign wr_release = wr_prev && !wr_active;

  // Wait-state generation
  logic [CNT_W-1:0] wait_cnt;
  io_wait_gen #(.WAIT_STATES(WAIT_STATES), .CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .cycle_active(cmd_hit), .wait_cnt(wait_cnt)
  );
  assign chrdy = !(cmd_hit && (wait_cnt != CNT_W'(WAIT_STATES)));

  // Write capture: last sample taken while the raw strobe is low
  logic [IDX_W-1:0] cap_idx;
  logic             cap_a0, cap_sbhe_n, cap_hit;
  logic [BUS_W-1:0] cap_data;
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_idx    <= '0;
      cap_a0     <= 1'b0;
      cap_sbhe_n <= 1'b0;
      cap_hit    <= 1'b0;
      cap_data   <= '0;
    end else if (!iow_n) begin
      cap_idx    <= rd_idx;
      cap_a0     <= addr[0];
      cap_sbhe_n <= sbhe_n;
      cap_hit    <= addr_hit;
      cap_data   <= data_in;
    end
  end

  logic wr_commit;
  assign wr_commit = wr_release && cap_hit;

  logic [BUS_W-1:0] rd_word;
  io_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .WIDE_MASK(WIDE_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_commit), .wr_idx(cap_idx),
    .wr_a0(cap_a0), .wr_sbhe_n(cap_sbhe_n), .wr_data(cap_data),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  // Read drive: turns on after synchronisation, off as soon as the strobe rises
  assign data_oe  = rd_active && !ior_n && iow_n && addr_hit;
  assign data_out = data_oe ? lane_present(rd_word, addr[0], sbhe_n) : '0;
endmodule

// File: rtl/io_slave_chk.sv
module io_slave_chk #(
  parameter int WAIT_STATES = 2,
  parameter int CNT_W       = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             aen,
  input logic             ior_n,
  input logic             iow_n,
  input logic             data_oe,
  input logic             iocs16_n,
  input logic             chrdy,
  input logic             cmd_hit,
  input logic             wr_active,
  input logic             wr_commit,
  input logic [CNT_W-1:0] wait_cnt
);
  p_aen_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    aen |-> (!data_oe && iocs16_n && chrdy));

  p_drive_only_read_r3: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (!ior_n && iow_n));

  p_commit_after_release_r4: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> (!wr_active && $past(wr_active)));

  p_wait_in_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    !chrdy |-> cmd_hit);

  p_ready_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && chrdy) |=> (chrdy || !cmd_hit));

  p_wait_counts_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_hit && !chrdy) |=> (!cmd_hit || (wait_cnt == $past(wait_cnt) + 1'b1)));

  p_reset_clears_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wait_cnt == '0));

  if (WAIT_STATES == 0) begin : g_zero
    p_zero_wait_r9: assert property (@(posedge clk) disable iff (rst) chrdy);
  end
endmodule

bind isa_io_slave io_slave_chk #(.WAIT_STATES(WAIT_STATES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .aen(aen), .ior_n(ior_n), .iow_n(iow_n),
  .data_oe(data_oe), .iocs16_n(iocs16_n), .chrdy(chrdy), .cmd_hit(cmd_hit),
  .wr_active(wr_active), .wr_commit(wr_commit), .wait_cnt(wait_cnt)
);

// File: tb/sim_isa_io_slave.sv
module sim_isa_io_slave;
  localparam int WAITN = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] addr = '0;
  logic        ior_n = 1'b1, iow_n = 1'b1, aen = 1'b0, sbhe_n = 1'b1;
  logic [15:0] din = '0;
  logic [15:0] dout0, dout1;
  logic        oe0, oe1, cs0, cs1, rdy0, rdy1;

  always #4 clk = ~clk;

  isa_io_slave #(.WAIT_STATES(WAITN)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .ior_n(ior_n), .iow_n(iow_n), .aen(aen),
    .sbhe_n(sbhe_n), .data_in(din), .data_out(dout0), .data_oe(oe0),
    .iocs16_n(cs0), .chrdy(rdy0));

  isa_io_slave #(.WAIT_STATES(0)) u1 (
    .clk(clk), .rst(rst), .addr(addr), .ior_n(ior_n), .iow_n(iow_n), .aen(aen),
    .sbhe_n(sbhe_n), .data_in(din), .data_out(dout1), .data_oe(oe1),
    .iocs16_n(cs1), .chrdy(rdy1));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] model [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [19:0] a);
    return (a[15:0] >= 16'h0300) && (a[15:0] <= 16'h031F);
  endfunction

  function automatic logic [15:0] lane_exp(input logic [15:0] w, input logic a0, input logic sb);
    int hi, lo;
    hi = int'(w) / 256;
    lo = int'(w) % 256;
    if (!a0) return sb ? 16'(lo) : w;
    return sb ? 16'(hi) : 16'(hi * 256);
  endfunction

  function automatic void model_write(input logic [19:0] a, input logic sb, input logic [15:0] d);
    int idx, hi, lo;
    idx = int'(a[4:1]);
    hi = int'(model[idx]) / 256;
    lo = int'(model[idx]) % 256;
    if (!a[0]) begin
      lo = int'(d) % 256;
      if (!sb) hi = int'(d) / 256;
    end else begin
      hi = sb ? int'(d) % 256 : int'(d) / 256;
    end
    if (idx >= 8) hi = 0;       // R7: narrow registers keep no high byte
    model[idx] = 16'(hi * 256 + lo);
  endfunction

  task automatic io_write(input logic [19:0] a, input logic sb, input logic [15:0] d,
                          input logic en);
    bit hit;
    @(negedge clk);
    addr = a; sbhe_n = sb; din = d; aen = en; iow_n = 1'b0;
    hit = in_win(a) && !en;
    #1;
    chk("R8 write ready at strobe", {31'd0, rdy0}, {31'd0, !hit});
    repeat (WAITN + 2) @(posedge clk);
    @(negedge clk);
    iow_n = 1'b1;
    repeat (4) @(negedge clk);
    aen = 1'b0;
    if (hit) model_write(a, sb, d);
  endtask

  task automatic io_read(input logic [19:0] a, input logic sb, input logic en);
    bit hit;
    int idx;
    string tag;
    @(negedge clk);
    addr = a; sbhe_n = sb; aen = en; ior_n = 1'b0;
    hit = in_win(a) && !en;
    idx = int'(a[4:1]);
    tag = (idx >= 8) ? "R7 narrow read" : "R5 lane read";
    #1;
    chk("R8 ready falls at once", {31'd0, rdy0}, {31'd0, !hit});
    chk("R9 zero-wait ready", {31'd0, rdy1}, 32'd1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 ready low after two edges", {31'd0, rdy0}, {31'd0, !hit});
    chk("R3 drive after sync", {31'd0, oe0}, {31'd0, hit});
    @(posedge clk);
    @(negedge clk);
    chk("R8 ready after wait states", {31'd0, rdy0}, 32'd1);
    if (hit) chk(tag, {16'd0, dout0}, {16'd0, lane_exp(model[idx], a[0], sb)});
    ior_n = 1'b1;
    #1;
    chk("R3 release on strobe rise", {31'd0, oe0}, 32'd0);
    repeat (3) @(negedge clk);
    aen = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 ready after reset", {31'd0, rdy0}, 32'd1);
    chk("R10 no drive after reset", {31'd0, oe0}, 32'd0);

    // R10: every location reads zero
    for (int i = 0; i < 16; i++) io_read(20'h00300 + 20'(2 * i), 1'b0, 1'b0);

    // R1/R4/R5: word writes then all four lane reads
    for (int i = 0; i < 16; i++)
      io_write(20'h00300 + 20'(2 * i), 1'b0, 16'(i * 16'h1111) ^ 16'hA5C3, 1'b0);
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 4; m++)
        io_read(20'h00300 + 20'(2 * i) + 20'(m / 2), m[0], 1'b0);

    // R5/R7: byte writes on each lane mode
    for (int i = 0; i < 16; i++) begin
      io_write(20'h00300 + 20'(2 * i), 1'b1, 16'hEE00 + 16'(i + 8'h40), 1'b0);
      io_read(20'h00300 + 20'(2 * i), 1'b0, 1'b0);
      io_write(20'h00301 + 20'(2 * i), 1'b0, {8'(i) ^ 8'h5A, 8'hCC}, 1'b0);
      io_read(20'h00300 + 20'(2 * i), 1'b0, 1'b0);
      io_write(20'h00301 + 20'(2 * i), 1'b1, {8'h77, 8'(i + 8'h90)}, 1'b0);
      io_read(20'h00300 + 20'(2 * i), 1'b0, 1'b0);
    end

    // R1/R2: misses and DMA-owned cycles change nothing
    io_write(20'h002FE, 1'b0, 16'hDEAD, 1'b0);
    io_write(20'h00320, 1'b0, 16'hBEEF, 1'b0);
    io_write(20'h00B00, 1'b0, 16'h1234, 1'b0);
    io_write(20'h00300, 1'b0, 16'hCAFE, 1'b1);
    io_write(20'h0031E, 1'b0, 16'hF00D, 1'b1);
    io_read(20'h00300, 1'b0, 1'b0);
    io_read(20'h0031E, 1'b0, 1'b0);
    io_read(20'h00320, 1'b0, 1'b0);
    io_read(20'h002FE, 1'b0, 1'b0);
    io_read(20'h00304, 1'b0, 1'b1);
    chk("R2 DMA read left no drive", {31'd0, oe0}, 32'd0);
    // R1: upper address bits are ignored
    io_write(20'h50302, 1'b0, 16'h4321, 1'b0);
    io_read(20'h00302, 1'b0, 1'b0);
    io_read(20'hF0302, 1'b0, 1'b0);

    // R4: data changed during the strobe is written with its final value
    @(negedge clk);
    addr = 20'h00306; sbhe_n = 1'b0; din = 16'h1111; iow_n = 1'b0;
    repeat (2) @(negedge clk);
    din = 16'h9876;
    repeat (3) @(negedge clk);
    iow_n = 1'b1;
    repeat (4) @(negedge clk);
    model[3] = 16'h9876;
    io_read(20'h00306, 1'b0, 1'b0);
    chk("R4 final sample stored", {16'd0, model[3]}, 32'h9876);

    // R6: chip-select sweep with address enable low and high
    for (int e = 0; e < 2; e++)
      for (int a = 16'h02F0; a <= 16'h0340; a++) begin
        bit exp_cs;
        @(negedge clk);
        addr = 20'(a); aen = e[0];
        #1;
        exp_cs = in_win(20'(a)) && (e == 0) && (((a / 2) % 16) < 8);
        chk("R6 chip select", {31'd0, cs0}, {31'd0, !exp_cs});
        if (e == 1) chk("R2 no chip select under DMA", {31'd0, cs0}, 32'd1);
      end
    @(negedge clk);
    aen = 1'b0;
    addr = 20'h10300;
    #1;
    chk("R6 alias selects wide register", {31'd0, cs0}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule